// File: doc/BRIEF.md
# Cache-Line Alert-on-Update Monitor

This block sits next to a private data cache and keeps a small record of cache lines that software has asked to watch. A user instruction marks a line as it loads it. Other instructions drop one mark or all marks. When the cache reports that a marked line was evicted or invalidated by coherence traffic, the block records an alert. It then raises a one-cycle redirect that sends the core to a user-level handler, with no operating-system involvement. At that moment the block saves the program counter of the interrupted instruction and keeps a cause code in a status word.

Software manages the monitor through a command port. Commands set or clear the handler address, enable alerts and disable alerts. Once an alert has been delivered, further alerts are masked until software enables alerts again. A context switch drops every mark and forces an alert, so the handler can mark its lines again. While the core is inside the kernel, alerts are held back and delivered after the kernel returns. The mark record is an N-entry table of line addresses. When a mark finds no free entry, the block reports that the line is not tracked, so software can fall back to validating it by hand. With one entry, the table is a single address register.

Top module: `aou_monitor`

## Requirements
- R1: After reset there are no marks, the status word is zero, the handler address is zero, and redir_valid, saved_pc and cmd_untracked are zero. Status layout: bit 4 enable, bit 3 masked, bit 2 pending, bits 1:0 cause (0 none, 1 eviction, 2 invalidation, 3 context switch).
- R2: Command codes on cmd_op are: 1 mark, 2 unmark, 3 unmark all, 4 set handler (from cmd_data), 5 enable, 6 disable. A mark of a line that is already marked takes no new entry. In the cycle after a mark, cmd_untracked is 1 only when the line was not present and the table was full, and 0 otherwise.
- R3: An event on a marked line (evt_kind 0 eviction, 1 invalidation) sets pending one cycle later, with cause 1 or 2, and removes that mark. An event on an unmarked line has no effect.
- R4: Unmark removes the mark of the addressed line, and unmark all removes every mark. Freed entries can be used again.
- R5: A pending alert that is enabled, unmasked, outside the kernel and has a non-zero handler produces redir_valid for exactly one cycle. The redirect carries the handler address on redir_target, and saved_pc holds cur_pc from the delivering edge. Pending then clears.
- R6: Delivery sets masked. While masked, new alerts stay pending and are not delivered. An enable command clears masked.
- R7: After a disable command no redirect is produced, and a pending alert is kept until alerts are enabled again.
- R8: While the handler address is zero, delivery is suppressed and the alert stays pending.
- R9: ctx_switch removes every mark and sets pending with cause 3.
- R10: While kern_active is high no redirect is produced. A held alert is delivered after kern_active falls.
- R11: Only one alert is pending at a time. A further alert that arrives while one is pending leaves the cause unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | LINE_W | Line address for mark and unmark |
| cmd_data | input | PC_W | Handler address for set handler |
| cmd_untracked | output | 1 | Mark found no free entry |
| evt_valid | input | 1 | Cache loss event strobe |
| evt_kind | input | 1 | 0 eviction, 1 invalidation |
| evt_addr | input | LINE_W | Line address of the lost line |
| ctx_switch | input | 1 | Context switch pulse |
| kern_active | input | 1 | Core is executing in the kernel |
| cur_pc | input | PC_W | Program counter of the current instruction |
| redir_valid | output | 1 | One-cycle redirect request |
| redir_target | output | PC_W | Handler address for the redirect |
| saved_pc | output | PC_W | PC captured at delivery |
| status | output | 5 | Enable, masked, pending, cause |

## Verification
The bench fills the table with a duplicate mark included, then marks one more line. A design that gave a repeated address its own entry would report a line as untracked too early. A design that did not free entries on unmark all or on a context switch fails when a fresh set of four lines is marked. The bench also raises an alert and then checks, in turn, that it stays pending while masked, while disabled, while the handler is zero and while in the kernel. A design that dropped any of these held alerts, or delivered it early, would produce a missing or unexpected redirect in the scoreboard. A second alert that arrives while one is pending must leave the first cause in place, which catches a design that lets the later alert overwrite the cause.

// File: rtl/aou_pkg.sv
package aou_pkg;
  localparam logic [2:0] OP_MARK        = 3'd1;
  localparam logic [2:0] OP_UNMARK      = 3'd2;
  localparam logic [2:0] OP_UNMARK_ALL  = 3'd3;
  localparam logic [2:0] OP_SET_HANDLER = 3'd4;
  localparam logic [2:0] OP_ENABLE      = 3'd5;
  localparam logic [2:0] OP_DISABLE     = 3'd6;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_EVICT = 2'd1;
  localparam logic [1:0] CAUSE_INVAL = 2'd2;
  localparam logic [1:0] CAUSE_CTX   = 2'd3;

  localparam int ST_W    = 5;
  localparam int ST_EN   = 4;
  localparam int ST_MASK = 3;
  localparam int ST_PEND = 2;
endpackage

// File: rtl/aou_mark_table.sv
module aou_mark_table #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mark_req,
  input  logic               unmark_req,
  input  logic               clear_all,
  input  logic [LINE_W-1:0]  cmd_addr,
  input  logic               evt_valid,
  input  logic [LINE_W-1:0]  evt_addr,
  output logic               evt_hit,
  output logic [ENTRIES-1:0] evt_hit_vec,
  output logic [ENTRIES-1:0] cmd_hit_vec,
  output logic               untracked
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [LINE_W-1:0]  tag [ENTRIES];
  logic [IDX_W-1:0]   free_idx;
  logic               free_found;
  logic               cmd_present;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign cmd_hit_vec[i] = vld[i] && (tag[i] == cmd_addr);
    assign evt_hit_vec[i] = evt_valid && vld[i] && (tag[i] == evt_addr);
  end

  assign evt_hit     = |evt_hit_vec;
  assign cmd_present = |cmd_hit_vec;

  if (ENTRIES == 1) begin : g_single
    assign free_idx   = '0;
    assign free_found = ~vld[0];
  end else begin : g_multi
    always_comb begin
      free_idx   = '0;
      free_found = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
        if (!vld[i]) begin
          free_idx   = IDX_W'(i);
          free_found = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      untracked <= 1'b0;
    end else begin
      untracked <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (clear_all || evt_hit_vec[i] || (unmark_req && cmd_hit_vec[i]))
          vld[i] <= 1'b0;
      end
      if (mark_req && !cmd_present) begin
        if (free_found) vld[free_idx] <= 1'b1;
        else            untracked     <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mark_req && !cmd_present && free_found)
      tag[free_idx] <= cmd_addr;
  end
endmodule

// File: rtl/aou_alert_ctrl.sv
module aou_alert_ctrl
  import aou_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            evt_hit,
  input  logic            evt_kind,
  input  logic            ctx_switch,
  input  logic            kern_active,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            set_handler,
  input  logic [PC_W-1:0] handler_in,
  input  logic            do_enable,
  input  logic            do_disable,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_target,
  output logic [PC_W-1:0] saved_pc,
  output logic            enable,
  output logic            masked,
  output logic            pending,
  output logic [1:0]      cause
);
  logic [PC_W-1:0] handler;
  logic            deliver;

  assign deliver = pending && enable && !masked && !kern_active && (handler != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      handler      <= '0;
      redir_valid  <= 1'b0;
      redir_target <= '0;
      saved_pc     <= '0;
      enable       <= 1'b0;
      masked       <= 1'b0;
      pending      <= 1'b0;
      cause        <= CAUSE_NONE;
    end else begin
      redir_valid <= deliver;
      if (set_handler) handler <= handler_in;
      if (do_enable) begin
        enable <= 1'b1;
        masked <= 1'b0;
      end
      if (do_disable) enable <= 1'b0;
      if (deliver) begin
        saved_pc     <= cur_pc;
        redir_target <= handler;
        masked       <= 1'b1;
      end
      if (ctx_switch) begin
        pending <= 1'b1;
        cause   <= CAUSE_CTX;
      end else if (evt_hit) begin
        pending <= 1'b1;
        if (!pending || deliver) cause <= evt_kind ? CAUSE_INVAL : CAUSE_EVICT;
      end else if (deliver) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aou_monitor.sv
module aou_monitor
  import aou_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  parameter int PC_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [LINE_W-1:0] cmd_addr,
  input  logic [PC_W-1:0]   cmd_data,
  output logic              cmd_untracked,
  input  logic              evt_valid,
  input  logic              evt_kind,
  input  logic [LINE_W-1:0] evt_addr,
  input  logic              ctx_switch,
  input  logic              kern_active,
  input  logic [PC_W-1:0]   cur_pc,
  output logic              redir_valid,
  output logic [PC_W-1:0]   redir_target,
  output logic [PC_W-1:0]   saved_pc,
  output logic [ST_W-1:0]   status
);
  logic               op_mark, op_unmark, op_clear, op_handler, op_en, op_dis;
  logic               tbl_evt_hit;
  logic [ENTRIES-1:0] tbl_evt_vec;
  logic [ENTRIES-1:0] tbl_cmd_vec;
  logic               st_en, st_mask, st_pend;
  logic [1:0]         st_cause;

  assign op_mark    = cmd_valid && (cmd_op == OP_MARK);
  assign op_unmark  = cmd_valid && (cmd_op == OP_UNMARK);
  assign op_clear   = (cmd_valid && (cmd_op == OP_UNMARK_ALL)) || ctx_switch;
  assign op_handler = cmd_valid && (cmd_op == OP_SET_HANDLER);
  assign op_en      = cmd_valid && (cmd_op == OP_ENABLE);
  assign op_dis     = cmd_valid && (cmd_op == OP_DISABLE);

  aou_mark_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_table (
    .clk         (clk),
    .rst         (rst),
    .mark_req    (op_mark),
    .unmark_req  (op_unmark),
    .clear_all   (op_clear),
    .cmd_addr    (cmd_addr),
    .evt_valid   (evt_valid),
    .evt_addr    (evt_addr),
    .evt_hit     (tbl_evt_hit),
    .evt_hit_vec (tbl_evt_vec),
    .cmd_hit_vec (tbl_cmd_vec),
    .untracked   (cmd_untracked)
  );

  aou_alert_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .evt_hit      (tbl_evt_hit),
    .evt_kind     (evt_kind),
    .ctx_switch   (ctx_switch),
    .kern_active  (kern_active),
    .cur_pc       (cur_pc),
    .set_handler  (op_handler),
    .handler_in   (cmd_data),
    .do_enable    (op_en),
    .do_disable   (op_dis),
    .redir_valid  (redir_valid),
    .redir_target (redir_target),
    .saved_pc     (saved_pc),
    .enable       (st_en),
    .masked       (st_mask),
    .pending      (st_pend),
    .cause        (st_cause)
  );

  assign status = {st_en, st_mask, st_pend, st_cause};
endmodule

// File: rtl/aou_monitor_chk.sv
module aou_monitor_chk
  import aou_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int PC_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               redir_valid,
  input logic [PC_W-1:0]    redir_target,
  input logic [ST_W-1:0]    status,
  input logic               ctx_switch,
  input logic               kern_active,
  input logic [ENTRIES-1:0] tbl_evt_vec,
  input logic [ENTRIES-1:0] tbl_cmd_vec
);
  a_r5_redir_one_cycle: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !redir_valid);

  a_r8_target_nonzero: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> (redir_target != '0));

  a_r6_masked_on_redir: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> status[ST_MASK]);

  a_r7_enabled_before_redir: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> $past(status[ST_EN]));

  a_r10_no_redir_from_kernel: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> !$past(kern_active));

  a_r9_ctx_sets_pending: assert property (@(posedge clk) disable iff (rst)
    ctx_switch |=> (status[ST_PEND] && status[1:0] == CAUSE_CTX));

  a_r2_unique_cmd_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tbl_cmd_vec));

  a_r3_unique_evt_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tbl_evt_vec));
endmodule

bind aou_monitor aou_monitor_chk #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .redir_valid  (redir_valid),
  .redir_target (redir_target),
  .status       (status),
  .ctx_switch   (ctx_switch),
  .kern_active  (kern_active),
  .tbl_evt_vec  (tbl_evt_vec),
  .tbl_cmd_vec  (tbl_cmd_vec)
);

// File: tb/aou_monitor_bench.sv
module aou_monitor_bench;
  localparam int ENTRIES = 4;
  localparam int LINE_W  = 26;
  localparam int PC_W    = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic [LINE_W-1:0] cmd_addr = '0;
  logic [PC_W-1:0]   cmd_data = '0;
  logic              cmd_untracked;
  logic              evt_valid = 1'b0;
  logic              evt_kind = 1'b0;
  logic [LINE_W-1:0] evt_addr = '0;
  logic              ctx_switch = 1'b0;
  logic              kern_active = 1'b0;
  logic [PC_W-1:0]   cur_pc = '0;
  logic              redir_valid;
  logic [PC_W-1:0]   redir_target;
  logic [PC_W-1:0]   saved_pc;
  logic [4:0]        status;

  typedef struct packed {
    logic [PC_W-1:0] tgt;
    logic [PC_W-1:0] pc;
  } exp_t;
  exp_t exp_q[$];

  int n_total = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  aou_monitor #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .PC_W(PC_W)) u_aou_monitor (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_untracked(cmd_untracked), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .evt_addr(evt_addr), .ctx_switch(ctx_switch),
    .kern_active(kern_active), .cur_pc(cur_pc), .redir_valid(redir_valid),
    .redir_target(redir_target), .saved_pc(saved_pc), .status(status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] st(input bit en, input bit mk, input bit pd, input logic [1:0] c);
    return {en, mk, pd, c};
  endfunction

  task automatic chk_st(input string req, input logic [4:0] exp);
    chk(status == exp, req, "status", 64'(status), 64'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [LINE_W-1:0] a, input logic [PC_W-1:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic mark_chk(input logic [LINE_W-1:0] a, input bit exp_untr, input string req);
    cmd(3'd1, a, '0);
    chk(cmd_untracked == exp_untr, req, "untracked", 64'(cmd_untracked), 64'(exp_untr));
  endtask

  task automatic evt(input logic [LINE_W-1:0] a, input bit kind);
    evt_valid = 1'b1; evt_addr = a; evt_kind = kind;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic expect_redir(input logic [PC_W-1:0] tgt, input logic [PC_W-1:0] pc);
    exp_t e;
    e.tgt = tgt; e.pc = pc;
    exp_q.push_back(e);
  endtask

  task automatic chk_drained(input string req);
    chk(exp_q.size() == 0, req, "pending expected redirects", 64'(exp_q.size()), 64'd0);
  endtask

  // Monitor: every redirect must match the next expected item
  always @(negedge clk) begin
    if (!rst && redir_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected redirect target", 64'(redir_target), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(redir_target == e.tgt, "R5", "redirect target", 64'(redir_target), 64'(e.tgt));
        chk(saved_pc == e.pc, "R5", "saved pc", 64'(saved_pc), 64'(e.pc));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk_st("R1", 5'd0);
    chk(redir_valid == 1'b0, "R1", "redir_valid", 64'(redir_valid), 64'd0);
    chk(cmd_untracked == 1'b0, "R1", "untracked", 64'(cmd_untracked), 64'd0);
    chk(saved_pc == '0, "R1", "saved_pc", 64'(saved_pc), 64'd0);

    cmd(3'd4, '0, 32'h1000);
    cmd(3'd5, '0, '0);
    chk_st("R1", st(1, 0, 0, 0));

    // R2 duplicate mark takes no entry, full table flags untracked
    mark_chk(26'h101, 0, "R2");
    mark_chk(26'h101, 0, "R2");
    mark_chk(26'h102, 0, "R2");
    mark_chk(26'h103, 0, "R2");
    mark_chk(26'h104, 0, "R2");
    mark_chk(26'h105, 1, "R2");

    // R3 event on an unmarked line does nothing
    evt(26'h105, 1'b0);
    idle(3);
    chk_st("R3", st(1, 0, 0, 0));

    // R3/R5 eviction of a marked line is delivered
    cur_pc = 32'h400;
    expect_redir(32'h1000, 32'h400);
    evt(26'h102, 1'b0);
    chk_st("R3", st(1, 0, 1, 1));
    idle(3);
    chk_drained("R5");
    chk_st("R6", st(1, 1, 0, 1));

    // R6 masked: invalidation held until enable
    evt(26'h103, 1'b1);
    idle(3);
    chk_st("R6", st(1, 1, 1, 2));
    cur_pc = 32'h500;
    expect_redir(32'h1000, 32'h500);
    cmd(3'd5, '0, '0);
    idle(3);
    chk_drained("R6");
    chk_st("R6", st(1, 1, 0, 2));

    // R11 second alert leaves the first cause
    evt(26'h104, 1'b0);
    chk_st("R11", st(1, 1, 1, 1));
    evt(26'h101, 1'b1);
    chk_st("R11", st(1, 1, 1, 1));
    cur_pc = 32'h600;
    expect_redir(32'h1000, 32'h600);
    cmd(3'd5, '0, '0);
    idle(3);
    chk_drained("R11");

    // R7 disabled alerts stay pending
    cmd(3'd5, '0, '0);
    cmd(3'd6, '0, '0);
    chk_st("R7", st(0, 0, 0, 1));
    cmd(3'd1, 26'h101, '0);
    evt(26'h101, 1'b0);
    idle(3);
    chk_st("R7", st(0, 0, 1, 1));

    // R8 zero handler suppresses delivery
    cmd(3'd4, '0, 32'h0);
    cmd(3'd5, '0, '0);
    idle(3);
    chk_st("R8", st(1, 0, 1, 1));
    cur_pc = 32'h700;
    expect_redir(32'h2000, 32'h700);
    cmd(3'd4, '0, 32'h2000);
    idle(3);
    chk_drained("R8");
    chk_st("R8", st(1, 1, 0, 1));

    // R4 unmark single and unmark all
    cmd(3'd5, '0, '0);
    cmd(3'd1, 26'h201, '0);
    cmd(3'd2, 26'h201, '0);
    evt(26'h201, 1'b0);
    idle(2);
    chk_st("R4", st(1, 0, 0, 1));
    cmd(3'd1, 26'h201, '0);
    cmd(3'd1, 26'h202, '0);
    cmd(3'd1, 26'h203, '0);
    cmd(3'd3, '0, '0);
    evt(26'h202, 1'b1);
    idle(2);
    chk_st("R4", st(1, 0, 0, 1));
    mark_chk(26'h301, 0, "R4");
    mark_chk(26'h302, 0, "R4");
    mark_chk(26'h303, 0, "R4");
    mark_chk(26'h304, 0, "R4");
    mark_chk(26'h305, 1, "R4");

    // R9 context switch inside the kernel, R10 deferral
    kern_active = 1'b1;
    cur_pc = 32'h800;
    ctx_switch = 1'b1;
    @(negedge clk);
    ctx_switch = 1'b0;
    chk_st("R9", st(1, 0, 1, 3));
    idle(3);
    chk_st("R10", st(1, 0, 1, 3));
    expect_redir(32'h2000, 32'h800);
    kern_active = 1'b0;
    idle(3);
    chk_drained("R10");
    chk_st("R9", st(1, 1, 0, 3));
    cmd(3'd5, '0, '0);
    evt(26'h301, 1'b0);
    idle(2);
    chk_st("R9", st(1, 0, 0, 3));
    mark_chk(26'h401, 0, "R9");
    mark_chk(26'h402, 0, "R9");
    mark_chk(26'h403, 0, "R9");
    mark_chk(26'h404, 0, "R9");

    // R10 ordinary alert raised inside the kernel
    kern_active = 1'b1;
    evt(26'h401, 1'b1);
    idle(3);
    chk_st("R10", st(1, 0, 1, 2));
    cur_pc = 32'h900;
    expect_redir(32'h2000, 32'h900);
    kern_active = 1'b0;
    idle(3);
    chk_drained("R10");
    chk_st("R10", st(1, 1, 0, 2));

    idle(2);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule